// File: doc/BRIEF.md
# Compact Floating-Point Multiplier

This block multiplies two numbers held in a small floating-point word of ten bits. Bit 9 is the sign. Bits 8:4 are a five-bit fraction of the form 0.1xxxx, stored together with its leading one. Bits 3:0 are a two's-complement exponent, so the value of a word is (-1)^sign × 0.mmmmm × 2^exp. A mantissa of all zeros stands for zero.

The caller presents both operands with a valid strobe. One clock later the block returns the product word with a valid strobe and two range flags. The result sign is the exclusive-or of the operand signs. The mantissas are multiplied as fractions. The exponents are added, and the result is renormalized with at most one left shift. Bits beyond the fifth fraction bit are truncated. A result that lands above the exponent range saturates and raises overflow. A result that lands below the range is flushed to zero and raises underflow.

Top module: `tiny_fp_mul`

## Requirements
- R1: If either operand has an all-zero mantissa (bits 8:4), the result is the all-zero word and neither flag is raised.
- R2: For nonzero operands that do not underflow, result bit 9 equals the exclusive-or of the two operand bits 9.
- R3: For nonzero operands, let P be the 10-bit product of the two 5-bit mantissas. If P bit 9 is 1, the result mantissa is P[9:5]; otherwise it is P[8:4]. Lower bits are discarded, so 0.11 × 2^4 times 0.101 × 2^-1 yields mantissa 11110 with exponent 2.
- R4: For nonzero operands in range, the result exponent (bits 3:0, two's complement) is the sum of the operand exponents, less one when P bit 9 is 0.
- R5: When that exponent exceeds +7, overflow is 1, underflow is 0 and the result is the operand sign-xor, mantissa 11111 and exponent 0111.
- R6: When that exponent is below -8, underflow is 1, overflow is 0 and the result is the all-zero word.
- R7: out_valid is 1 exactly in the cycle after a cycle with in_valid 1, and the result and flags in that cycle belong to those operands.
- R8: While in_valid is 0, the result and flags keep their last values, whatever the operand inputs do.
- R9: During reset, out_valid, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are present this cycle |
| op_a | input | 10 | First operand {sign, mantissa, exponent} |
| op_b | input | 10 | Second operand {sign, mantissa, exponent} |
| out_valid | output | 1 | Result is present this cycle |
| product | output | 10 | Result word {sign, mantissa, exponent} |
| overflow | output | 1 | Exponent exceeded +7; result saturated |
| underflow | output | 1 | Exponent fell below -8; result flushed to zero |

## Verification
The bench sweeps every normalized mantissa and zero against every exponent for both operands, about 74,000 pairs, and compares each result with an arithmetic model. This covers the split between products that need the one-bit shift and products that do not. A design that took its mantissa from the wrong half of P would show doubled or halved mantissas. A design that forgot the decrement would give exponents one too high. The sweep also covers the exponent edges, where a sum of exactly +7 or -8 must pass unchanged. A unit with an off-by-one compare, or with only five exponent bits, would saturate or flush those results, or wrap them into false values. Zero operands with extreme exponents catch a flush that leaks a sign or a flag. A stretch with in_valid held low and the operands changing catches outputs that follow the inputs without the strobe.

// File: rtl/tiny_fp_mul.sv
module tiny_fp_mul #(
  parameter int MANT_W = 5,
  parameter int EXP_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [MANT_W+EXP_W:0]       op_a,
  input  logic [MANT_W+EXP_W:0]       op_b,
  output logic                        out_valid,
  output logic [MANT_W+EXP_W:0]       product,
  output logic                        overflow,
  output logic                        underflow
);

  localparam int WORD_W = MANT_W + EXP_W + 1;
  localparam int PROD_W = 2 * MANT_W;
  localparam int SUM_W  = EXP_W + 2;
  localparam logic signed [SUM_W-1:0] EXP_MAX = SUM_W'((2 ** (EXP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] EXP_MIN = SUM_W'(-(2 ** (EXP_W - 1)));

  logic              sgn_a, sgn_b, sgn_r;
  logic [MANT_W-1:0] man_a, man_b, man_n;
  logic [EXP_W-1:0]  exp_a, exp_b;
  logic [PROD_W-1:0] raw;
  logic              top_set, nonzero;
  logic signed [SUM_W-1:0] exp_sum;
  logic              ovf_c, unf_c;
  logic [WORD_W-1:0] res_c;

  assign sgn_a = op_a[WORD_W-1];
  assign sgn_b = op_b[WORD_W-1];
  assign man_a = op_a[WORD_W-2 -: MANT_W];
  assign man_b = op_b[WORD_W-2 -: MANT_W];
  assign exp_a = op_a[EXP_W-1:0];
  assign exp_b = op_b[EXP_W-1:0];

  assign sgn_r   = sgn_a ^ sgn_b;
  assign nonzero = (|man_a) & (|man_b);
  assign raw     = {{MANT_W{1'b0}}, man_a} * {{MANT_W{1'b0}}, man_b};
  assign top_set = raw[PROD_W-1];
  assign man_n   = top_set ? raw[PROD_W-1 -: MANT_W] : raw[PROD_W-2 -: MANT_W];

  assign exp_sum = $signed({{2{exp_a[EXP_W-1]}}, exp_a})
                 + $signed({{2{exp_b[EXP_W-1]}}, exp_b})
                 - $signed({{(SUM_W-1){1'b0}}, ~top_set});

  assign ovf_c = nonzero && (exp_sum > EXP_MAX);
  assign unf_c = nonzero && (exp_sum < EXP_MIN);

  always_comb begin
    if (!nonzero || unf_c)
      res_c = '0;
    else if (ovf_c)
      res_c = {sgn_r, {MANT_W{1'b1}}, 1'b0, {(EXP_W-1){1'b1}}};
    else
      res_c = {sgn_r, man_n, exp_sum[EXP_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product   <= res_c;
        overflow  <= ovf_c;
        underflow <= unf_c;
      end
    end
  end

endmodule

// File: rtl/tiny_fp_mul_chk.sv
module tiny_fp_mul_chk #(
  parameter int MANT_W = 5,
  parameter int EXP_W  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [MANT_W+EXP_W:0] op_a,
  input logic [MANT_W+EXP_W:0] op_b,
  input logic                  out_valid,
  input logic [MANT_W+EXP_W:0] product,
  input logic                  overflow,
  input logic                  underflow
);

  localparam int TOP = MANT_W + EXP_W;

  logic zero_in;
  assign zero_in = (op_a[TOP-1 -: MANT_W] == '0) || (op_b[TOP-1 -: MANT_W] == '0);

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero_in) |=> (product == '0 && !overflow && !underflow)); // R1

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zero_in) |=> (underflow || product[TOP] == $past(op_a[TOP] ^ op_b[TOP]))); // R2

  AST_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && product[TOP-1 -: MANT_W] != '0) |-> product[TOP-1]); // R3

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (product[TOP-1 -: MANT_W] == '1 && product[EXP_W-1:0] == {1'b0, {(EXP_W-1){1'b1}}})); // R5

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (product == '0 && !overflow)); // R6

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(product) && $stable(overflow) && $stable(underflow))); // R8

endmodule

bind tiny_fp_mul tiny_fp_mul_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .product(product), .overflow(overflow), .underflow(underflow)
);

// File: tb/test_tiny_fp_mul.sv
module test_tiny_fp_mul;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] op_a = '0;
  logic [9:0] op_b = '0;
  logic       out_valid;
  logic [9:0] product;
  logic       overflow;
  logic       underflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tiny_fp_mul i_tiny_fp_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product), .overflow(overflow), .underflow(underflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (a=%b b=%b)", req, act, exp, op_a, op_b);
    end
  endtask

  // returns {ovf, unf, word}
  function automatic logic [11:0] model(input logic [9:0] a, input logic [9:0] b);
    int ma, mb, p, e, m;
    logic s;
    ma = int'(a[8:4]);
    mb = int'(b[8:4]);
    s  = a[9] ^ b[9];
    if (ma == 0 || mb == 0) return 12'h000;
    p = ma * mb;
    e = int'($signed(a[3:0])) + int'($signed(b[3:0]));
    if (p >= 512) m = p / 32;
    else begin m = (p / 16) % 32; e = e - 1; end
    if (e > 7)  return {1'b1, 1'b0, s, 5'b11111, 4'b0111};
    if (e < -8) return {1'b0, 1'b1, 10'b0};
    return {2'b00, s, m[4:0], e[3:0]};
  endfunction

  task automatic apply_and_check(input logic [9:0] a, input logic [9:0] b);
    logic [11:0] exp_v;
    op_a = a;
    op_b = b;
    in_valid = 1'b1;
    exp_v = model(a, b);
    @(negedge clk);
    check("R7 valid", int'(out_valid), 1);
    if (a[8:4] == 0 || b[8:4] == 0) begin
      check("R1 zero word", int'(product), 0);
      check("R1 flags", int'({overflow, underflow}), 0);
    end else begin
      check("R5 overflow", int'(overflow), int'(exp_v[11]));
      check("R6 underflow", int'(underflow), int'(exp_v[10]));
      if (exp_v[10]) check("R6 flush", int'(product), 0);
      else begin
        check("R2 sign", int'(product[9]), int'(exp_v[9]));
        check(exp_v[11] ? "R5 saturated mantissa" : "R3 mantissa", int'(product[8:4]), int'(exp_v[8:4]));
        check(exp_v[11] ? "R5 saturated exponent" : "R4 exponent", int'(product[3:0]), int'(exp_v[3:0]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    logic [1:0] held_f;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 product", int'(product), 0);
    check("R9 flags", int'({overflow, underflow}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset", int'(out_valid), 0);

    // R3, R4: worked example 0.11*2^4 x 0.101*2^-1 = 0.1111*2^2
    apply_and_check({1'b0, 5'b11000, 4'b0100}, {1'b0, 5'b10100, 4'b1111});
    check("R3 example", int'(product), int'({1'b0, 5'b11110, 4'b0010}));

    // exhaustive sweep: mantissa 0 or 16..31, every exponent, both signs alternating
    for (int ia = 0; ia < 17; ia++) begin
      for (int xa = 0; xa < 16; xa++) begin
        for (int ib = 0; ib < 17; ib++) begin
          for (int xb = 0; xb < 16; xb++) begin
            logic [4:0] ma, mb;
            ma = (ia == 0) ? 5'd0 : 5'(15 + ia);
            mb = (ib == 0) ? 5'd0 : 5'(15 + ib);
            apply_and_check({1'(xa + ib), ma, 4'(xa)}, {1'(xb + ia + 1), mb, 4'(xb)});
          end
        end
      end
    end

    // R8: idle with changing operands leaves outputs untouched
    apply_and_check({1'b1, 5'b11111, 4'b0111}, {1'b0, 5'b11111, 4'b0111});
    held = product;
    held_f = {overflow, underflow};
    in_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      op_a = {1'b0, 5'(16 + k), 4'(k)};
      op_b = {1'b1, 5'b10000, 4'b1000};
      @(negedge clk);
      check("R7 no valid when idle", int'(out_valid), 0);
      check("R8 product held", int'(product), int'(held));
      check("R8 flags held", int'({overflow, underflow}), int'(held_f));
    end

    // R7: valid returns on the next strobe
    apply_and_check({1'b0, 5'b10000, 4'b0000}, {1'b0, 5'b10000, 4'b0000});
    check("R4 half squared", int'(product), int'({1'b0, 5'b10000, 4'b1111}));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule